// File: doc/BRIEF.md
# Segment-Sequenced Raster Timing Generator with Movable Window

This block produces the horizontal and vertical timing of a 640x480, 60 Hz raster from a 25 MHz dot clock. It also marks a 512x256 inner window inside the visible area and reports coordinates relative to that window. Each axis is not built from a set of comparators. Instead, it walks a short list of segments. Every segment carries a few control bits (sync, visible, window, where its length comes from, wrap) and a terminal count. A per-segment counter runs from 0 up to that terminal count. It then clears, and the segment index moves on. The last segment sends the index back to 0.

The two margin segments on each axis, one before the window and one after it, take their lengths from a margin register rather than from the fixed list. Each margin register holds a leading and a trailing value, and their sum stays constant. A two-bit command moves the window: it shifts one count from one margin to the other, or restores the centred position. The line length and the frame length never change. A command is collected at any time but takes effect only at the start of the next frame.

Top module: `vgawin_ctrl`

## Requirements
- R1: While `rst` is high and at the first falling clock edge after it is released, `hsync_n` and `vsync_n` are 1, `vga_valid` and `win_valid` are 0, and `x` and `y` are 0. Reset sets both margins of each axis to their initial value (63 horizontal, 111 vertical).
- R2: Each line is the sum of these segment lengths: sync 96, back porch 48, leading margin (lead+1), window 2^XW = 512, trailing margin (trail+1), front porch 16. That gives 800 clocks with centred margins. `hsync_n` is 0 exactly during the sync segment.
- R3: The vertical position advances once per line. A frame is made of sync 2, back porch 33, leading margin (lead+1), window 2^YW = 256, trailing margin (trail+1) and front porch 10 lines, which gives 525 lines. `vsync_n` is 0 for the whole of each sync line.
- R4: `vga_valid` is 1 exactly when both axes are in a margin or window segment.
- R5: `win_valid` is 1 exactly when both axes are in their window segment. `x` counts 0 to 2^XW-1 across the horizontal window and is 0 elsewhere. `y` counts 0 to 2^YW-1 across the window lines and is 0 elsewhere.
- R6: Every output is one clock behind the internal raster position, and all outputs share that latency. The first edge after reset shows frame position 0 (line 0, clock 0). So at the second falling edge after release, `hsync_n` and `vsync_n` are both 0.
- R7: Command encoding per axis: 01 adds one to the leading margin and subtracts one from the trailing margin; 10 does the opposite; 11 sets both margins back to their initial value; 00 does nothing.
- R8: A command changes the margins only at the boundary into a new frame. The frame in which the command arrives keeps its old margins. When several non-zero commands arrive within one frame, the last one is applied.
- R9: Each margin stays within 0 to OFF_MAX (127 by default). A step that would push either margin of the pair out of that range leaves both margins unchanged. The line and frame lengths therefore never change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| hcmd | input | 2 | Horizontal window move command (R7 encoding) |
| vcmd | input | 2 | Vertical window move command (R7 encoding) |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| vga_valid | output | 1 | Raster is inside the visible area |
| win_valid | output | 1 | Raster is inside the inner window |
| x | output | XW | Column within the window |
| y | output | YW | Row within the window |

## Verification
The bench builds the block with shrunken segment lengths. The sync, porch and window lengths are a few clocks or lines, the initial margins are 3 and 2, and OFF_MAX is 5. The result is a 25-clock line and a 16-line frame. With these values, every position of a whole frame can be compared against a position-derived expectation, over a dozen frames. The small OFF_MAX also brings both clamp edges within a handful of commands: a leading margin stuck at its maximum, and a trailing margin stuck at zero. The same setup covers several commands arriving in one frame.

// File: rtl/vgawin_pkg.sv
package vgawin_pkg;

    localparam int DUR_W = 10;
    localparam int IDX_W = 3;

    typedef enum logic [1:0] {
        CMD_NONE     = 2'b00,
        CMD_LEAD_UP  = 2'b01,
        CMD_LEAD_DN  = 2'b10,
        CMD_RECENTRE = 2'b11
    } off_cmd_e;

    typedef struct packed {
        logic sync_on;
        logic visible;
        logic window;
        logic from_off;
        logic off_sel;
        logic wrap;
    } seg_ctrl_t;

    typedef struct packed {
        seg_ctrl_t          ctrl;
        logic [DUR_W-1:0]   tc;
    } seg_entry_t;

    // Effective terminal count of a segment: fixed entry or a margin value
    function automatic logic [DUR_W-1:0] seg_len(seg_entry_t e,
                                                 logic [DUR_W-1:0] lead,
                                                 logic [DUR_W-1:0] trail);
        if (e.ctrl.from_off)
            return e.ctrl.off_sel ? trail : lead;
        return e.tc;
    endfunction

endpackage

// File: rtl/vgawin_margin.sv
module vgawin_margin
    import vgawin_pkg::*;
#(
    parameter int INIT    = 63,
    parameter int OFF_MAX = 127
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cmd,
    input  logic             apply,
    output logic [DUR_W-1:0] lead,
    output logic [DUR_W-1:0] trail
);
    localparam logic [DUR_W-1:0] INIT_V = DUR_W'(INIT);
    localparam logic [DUR_W-1:0] MAX_V  = DUR_W'(OFF_MAX);

    off_cmd_e pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            lead  <= INIT_V;
            trail <= INIT_V;
            pend  <= CMD_NONE;
        end else if (apply) begin
            case (pend)
                CMD_LEAD_UP: if (lead < MAX_V && trail != '0) begin
                    lead  <= lead + 1'b1;
                    trail <= trail - 1'b1;
                end
                CMD_LEAD_DN: if (trail < MAX_V && lead != '0) begin
                    lead  <= lead - 1'b1;
                    trail <= trail + 1'b1;
                end
                CMD_RECENTRE: begin
                    lead  <= INIT_V;
                    trail <= INIT_V;
                end
                default: ;
            endcase
            pend <= off_cmd_e'(cmd);
        end else if (cmd != 2'b00) begin
            pend <= off_cmd_e'(cmd);
        end
    end

    a_r9_clamp: assert property (@(posedge clk) disable iff (rst)
        lead <= MAX_V && trail <= MAX_V);

    a_r8_hold_midframe: assert property (@(posedge clk) disable iff (rst)
        !apply |=> $stable(lead) && $stable(trail));

endmodule

// File: rtl/vgawin_axis.sv
module vgawin_axis
    import vgawin_pkg::*;
#(
    parameter int SYNC_TC  = 95,
    parameter int BACK_TC  = 47,
    parameter int CW       = 9,
    parameter int FRONT_TC = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [DUR_W-1:0] lead,
    input  logic [DUR_W-1:0] trail,
    output logic             last,
    output logic             sync_o,
    output logic             vis_o,
    output logic             win_o,
    output logic [CW-1:0]    coord_o
);
    localparam logic [DUR_W-1:0] SYNC_V  = DUR_W'(SYNC_TC);
    localparam logic [DUR_W-1:0] BACK_V  = DUR_W'(BACK_TC);
    localparam logic [DUR_W-1:0] WIN_V   = DUR_W'((1 << CW) - 1);
    localparam logic [DUR_W-1:0] FRONT_V = DUR_W'(FRONT_TC);

    logic [IDX_W-1:0] idx;
    logic [DUR_W-1:0] cnt;
    seg_entry_t       ent;
    logic [DUR_W-1:0] tc_cur;
    logic             at_end;

    // Segment list: sync, back porch, lead margin, window, trail margin, front porch
    always_comb begin
        ent = '0;
        case (idx)
            3'd0: begin ent.ctrl.sync_on = 1'b1; ent.tc = SYNC_V; end
            3'd1: begin ent.tc = BACK_V; end
            3'd2: begin ent.ctrl.visible = 1'b1; ent.ctrl.from_off = 1'b1; end
            3'd3: begin ent.ctrl.visible = 1'b1; ent.ctrl.window = 1'b1; ent.tc = WIN_V; end
            3'd4: begin ent.ctrl.visible = 1'b1; ent.ctrl.from_off = 1'b1;
                        ent.ctrl.off_sel = 1'b1; end
            3'd5: begin ent.ctrl.wrap = 1'b1; ent.tc = FRONT_V; end
            default: begin ent.ctrl.wrap = 1'b1; end
        endcase
    end

    assign tc_cur = seg_len(ent, lead, trail);
    assign at_end = (cnt == tc_cur);
    assign last   = step && at_end && ent.ctrl.wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx     <= '0;
            cnt     <= '0;
            sync_o  <= 1'b0;
            vis_o   <= 1'b0;
            win_o   <= 1'b0;
            coord_o <= '0;
        end else begin
            if (step) begin
                if (at_end) begin
                    cnt <= '0;
                    idx <= ent.ctrl.wrap ? '0 : idx + 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            sync_o  <= ent.ctrl.sync_on;
            vis_o   <= ent.ctrl.visible;
            win_o   <= ent.ctrl.window;
            coord_o <= ent.ctrl.window ? cnt[CW-1:0] : '0;
        end
    end

    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= tc_cur);

    a_r3_hold_between_steps: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(idx) && $stable(cnt));

    a_r5_win_in_visible: assert property (@(posedge clk) disable iff (rst)
        win_o |-> vis_o);

endmodule

// File: rtl/vgawin_ctrl.sv
module vgawin_ctrl
    import vgawin_pkg::*;
#(
    parameter int H_SYNC_TC  = 95,
    parameter int H_BACK_TC  = 47,
    parameter int H_MARGIN   = 63,
    parameter int XW         = 9,
    parameter int H_FRONT_TC = 15,
    parameter int V_SYNC_TC  = 1,
    parameter int V_BACK_TC  = 32,
    parameter int V_MARGIN   = 111,
    parameter int YW         = 8,
    parameter int V_FRONT_TC = 9,
    parameter int OFF_MAX    = 127
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    hcmd,
    input  logic [1:0]    vcmd,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          vga_valid,
    output logic          win_valid,
    output logic [XW-1:0] x,
    output logic [YW-1:0] y
);
    logic [DUR_W-1:0] h_lead, h_trail, v_lead, v_trail;
    logic h_last, v_last, frame_edge;
    logic h_sync, h_vis, h_win, v_sync, v_vis, v_win;

    assign frame_edge = h_last && v_last;

    vgawin_margin #(.INIT(H_MARGIN), .OFF_MAX(OFF_MAX)) u_hmar (
        .clk(clk), .rst(rst), .cmd(hcmd), .apply(frame_edge),
        .lead(h_lead), .trail(h_trail));

    vgawin_margin #(.INIT(V_MARGIN), .OFF_MAX(OFF_MAX)) u_vmar (
        .clk(clk), .rst(rst), .cmd(vcmd), .apply(frame_edge),
        .lead(v_lead), .trail(v_trail));

    vgawin_axis #(.SYNC_TC(H_SYNC_TC), .BACK_TC(H_BACK_TC), .CW(XW),
                  .FRONT_TC(H_FRONT_TC)) u_hax (
        .clk(clk), .rst(rst), .step(1'b1), .lead(h_lead), .trail(h_trail),
        .last(h_last), .sync_o(h_sync), .vis_o(h_vis), .win_o(h_win), .coord_o(x));

    vgawin_axis #(.SYNC_TC(V_SYNC_TC), .BACK_TC(V_BACK_TC), .CW(YW),
                  .FRONT_TC(V_FRONT_TC)) u_vax (
        .clk(clk), .rst(rst), .step(h_last), .lead(v_lead), .trail(v_trail),
        .last(v_last), .sync_o(v_sync), .vis_o(v_vis), .win_o(v_win), .coord_o(y));

    assign hsync_n   = ~h_sync;
    assign vsync_n   = ~v_sync;
    assign vga_valid = h_vis & v_vis;
    assign win_valid = h_win & v_win;

    a_r5_x_step: assert property (@(posedge clk) disable iff (rst)
        h_win && $past(h_win) |-> (x - $past(x)) == XW'(1));

    a_r2_no_sync_in_window: assert property (@(posedge clk) disable iff (rst)
        !(!hsync_n && win_valid));

    a_r3_vsync_line_edge: assert property (@(posedge clk) disable iff (rst)
        $fell(vsync_n) |-> $fell(hsync_n));

endmodule

// File: tb/vgawin_ctrl_tb.sv
module vgawin_ctrl_tb;
    localparam int HS_TC = 3, HB_TC = 2, HO = 3, XW = 3, HF_TC = 1;
    localparam int VS_TC = 1, VB_TC = 1, VO = 2, YW = 2, VF_TC = 1;
    localparam int OMAX  = 5;

    logic clk = 1'b0, rst = 1'b1;
    logic [1:0] hcmd = 2'b00, vcmd = 2'b00;
    logic hsync_n, vsync_n, vga_valid, win_valid;
    logic [XW-1:0] x;
    logic [YW-1:0] y;

    int checks = 0, errors = 0;
    int lh = HO, th = HO, lv = VO, tv = VO;
    bit done = 0;

    always #4 clk = ~clk;

    vgawin_ctrl #(
        .H_SYNC_TC(HS_TC), .H_BACK_TC(HB_TC), .H_MARGIN(HO), .XW(XW), .H_FRONT_TC(HF_TC),
        .V_SYNC_TC(VS_TC), .V_BACK_TC(VB_TC), .V_MARGIN(VO), .YW(YW), .V_FRONT_TC(VF_TC),
        .OFF_MAX(OMAX)
    ) u_dut (
        .clk(clk), .rst(rst), .hcmd(hcmd), .vcmd(vcmd),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .vga_valid(vga_valid),
        .win_valid(win_valid), .x(x), .y(y));

    task automatic chk(bit ok, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Margin model per R7 and R9
    function automatic void upd(inout int l, inout int t, input int c, input int init);
        case (c)
            1: if (l < OMAX && t > 0) begin l++; t--; end
            2: if (t < OMAX && l > 0) begin l--; t++; end
            3: begin l = init; t = init; end
            default: ;
        endcase
    endfunction

    task automatic do_reset();
        rst = 1'b1; hcmd = 2'b00; vcmd = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(hsync_n && vsync_n, "R1 syncs idle in reset", {hsync_n, vsync_n}, 3);
        chk(!vga_valid && !win_valid, "R1 flags low in reset", {vga_valid, win_valid}, 0);
        rst = 1'b0;
        chk(hsync_n && vsync_n && !vga_valid && !win_valid && x == 0 && y == 0,
            "R1 outputs at release", {hsync_n, vsync_n, vga_valid, win_valid}, 12);
        lh = HO; th = HO; lv = VO; tv = VO;
    endtask

    // One whole frame; commands issued at positions 5 and 20 (R8)
    task automatic run_frame(string tag, int hc1, int vc1, int hc2, int vc2);
        int hs = HS_TC + 1, hvs = HS_TC + 1 + HB_TC + 1;
        int hws = hvs + lh + 1, hve = hws + (1 << XW) + th + 1, ht = hve + HF_TC + 1;
        int vs = VS_TC + 1, vvs = VS_TC + 1 + VB_TC + 1;
        int vws = vvs + lv + 1, vve = vws + (1 << YW) + tv + 1, vt = vve + VF_TC + 1;
        int bh = 0, bv = 0, bvis = 0, bwin = 0;
        int ah = 0, eh = 0, av = 0, ev = 0, avis = 0, evis = 0, aw = 0, ew = 0;
        for (int p = 0; p < ht * vt; p++) begin
            int hp, vp, e_hs, e_vs, e_vis, e_win, e_x, e_y, hwin, vwin;
            @(negedge clk);
            hp = p % ht; vp = p / ht;
            e_hs  = (hp < hs) ? 0 : 1;
            e_vs  = (vp < vs) ? 0 : 1;
            e_vis = (hp >= hvs && hp < hve && vp >= vvs && vp < vve) ? 1 : 0;
            hwin  = (hp >= hws && hp < hws + (1 << XW)) ? 1 : 0;
            vwin  = (vp >= vws && vp < vws + (1 << YW)) ? 1 : 0;
            e_win = hwin & vwin;
            e_x   = hwin ? hp - hws : 0;
            e_y   = vwin ? vp - vws : 0;
            if (int'(hsync_n) != e_hs && bh++ == 0) begin ah = hsync_n; eh = e_hs + 10 * p; end
            if (int'(vsync_n) != e_vs && bv++ == 0) begin av = vsync_n; ev = e_vs + 10 * p; end
            if (int'(vga_valid) != e_vis && bvis++ == 0) begin avis = vga_valid; evis = e_vis + 10 * p; end
            if ((int'(win_valid) != e_win || int'(x) != e_x || int'(y) != e_y) && bwin++ == 0) begin
                aw = 10000 * int'(win_valid) + 100 * int'(x) + int'(y);
                ew = 10000 * e_win + 100 * e_x + e_y;
            end
            if (p == 5) begin hcmd = 2'(hc1); vcmd = 2'(vc1); end
            else if (p == 20) begin hcmd = 2'(hc2); vcmd = 2'(vc2); end
            else begin hcmd = 2'b00; vcmd = 2'b00; end
        end
        chk(bh == 0, {tag, " R2 R6 hsync timing"}, ah, eh);
        chk(bv == 0, {tag, " R3 vsync timing"}, av, ev);
        chk(bvis == 0, {tag, " R4 visible area"}, avis, evis);
        chk(bwin == 0, {tag, " R5 window flag and coords"}, aw, ew);
        upd(lh, th, (hc2 != 0) ? hc2 : hc1, HO);
        upd(lv, tv, (vc2 != 0) ? vc2 : vc1, VO);
    endtask

    initial begin
        do_reset();
        run_frame("R1 centred, R7 lead up issued", 1, 0, 0, 0);
        run_frame("R8 lead up seen, R7 up again", 1, 0, 0, 0);
        run_frame("R9 h lead at max, up again", 1, 0, 0, 0);
        run_frame("R9 h clamped, R7 recentre", 3, 0, 0, 0);
        run_frame("R7 recentred, lead down", 2, 0, 0, 0);
        run_frame("R8 last command wins", 1, 1, 2, 0);
        run_frame("R8 applied, v up", 0, 1, 0, 0);
        run_frame("R9 v trail at zero, up again", 0, 1, 0, 0);
        run_frame("R9 v clamped, both recentre", 3, 3, 0, 0);
        run_frame("R7 both recentred", 0, 0, 0, 0);
        do_reset();
        run_frame("R1 margins reinit after reset", 0, 0, 0, 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule